// File: doc/BRIEF.md
# Parallel Flash Word Programming Controller

This controller writes a run of words from a local source buffer into a parallel flash device. It handles one address at a time. For each word it sends the four-write program command, then reads the device again and again until the device reports that its internal program cycle has finished. If asked to, it reads the word back to confirm it. It then moves to the next address, and it stops after the last one. One `done` pulse marks the end of every request. `error` tells a failed run from a clean one and keeps its value until the next request is accepted.

The host starts a request with a one-cycle `start` pulse. The pulse carries a base address, a word count and a verify enable. The controller reads the source buffer through an index port that uses combinational read data. Each flash bus access lasts one cycle: either a write strobe, or a read strobe whose data the device returns on the following cycle.

The state machine has these states:

- `ST_IDLE` waits for a request.
- `ST_UNLK1`, `ST_UNLK2`, `ST_SETUP` and `ST_WORD` carry the four command writes.
- `ST_POLL_RD` and `ST_POLL_EV` issue a status read and then judge it.
- `ST_RECHK_RD` and `ST_RECHK_EV` make the single confirming re-read.
- `ST_VER_RD` and `ST_VER_EV` read the word back and compare it.
- `ST_NEXT` either advances to the next word or finishes.
- `ST_FAIL` records an error.
- `ST_FIN` pulses `done`.

The transitions are:

- From `ST_IDLE`, a start with a zero count goes to `ST_FIN`, and any other start goes to `ST_UNLK1`.
- The four write states step in order into `ST_POLL_RD`.
- From `ST_POLL_EV`:
  - if the poll bit matches, go to `ST_VER_RD`, or to `ST_NEXT` when verify is off;
  - if the poll bit still differs and the fail bit is set, go to `ST_RECHK_RD`;
  - otherwise go back to `ST_POLL_RD`.
- From `ST_RECHK_EV`, a match goes on as from a good poll, and a mismatch goes to `ST_FAIL`.
- From `ST_VER_EV`, a match goes to `ST_NEXT` and a mismatch goes to `ST_FAIL`.
- From `ST_NEXT`, the last word goes to `ST_FIN`, and any other word goes to `ST_UNLK1`.
- `ST_FAIL` goes to `ST_FIN`, and `ST_FIN` goes to `ST_IDLE`.

Top module: `flash_prog_ctrl`

## Requirements
- R1: During reset and whenever the block is idle, `fl_we`, `fl_re`, `done` and `busy` are low. After reset, `error` is low.
- R2: Each word begins with four consecutive write cycles, one per clock:
  - data 0xAA to address 0x555;
  - data 0x55 to address 0x2AA;
  - data 0xA0 to address 0x555;
  - the source word to the word's target address.

  The first of these writes comes in the cycle after an accepted start with a nonzero count.
- R3: After the data write, the block reads the target address. It judges the value the device returns in the next cycle, and it repeats the read as long as data bit 7 differs from bit 7 of the source word and data bit 5 is 0.
- R4: If a status read has bit 7 mismatching and bit 5 set, the block reads the target once more.
  - If bit 7 of that re-read matches, the word continues normally.
  - Otherwise `error` is set and no further bus cycle is issued for the request.
- R5: With verify enabled, one extra read of the target address follows a good poll. If the returned word differs in any bit from the source word, `error` is set and the request ends with no further bus cycle.
- R6: With verify disabled, the block issues no read-back cycle. The next word's command writes follow directly after the good poll.
- R7: Word i, counting from 0, is taken from source index i and programmed at base address plus i. After word count minus one, the request ends. On success the flash holds every source word at its address.
- R8: A start with a count of zero produces a `done` pulse within three cycles and no bus cycle at all.
- R9: `done` is a single-cycle pulse at the end of every request, whether it succeeded or failed. `error` is cleared when a request is accepted and otherwise keeps its value while the block is idle.
- R10: A `start` pulse that arrives while `busy` is high has no effect on the bus sequence or the outcome of the current request.
- R11: `fl_we` and `fl_re` are never high together, and no read strobe lasts longer than one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request pulse, taken only when idle |
| len | input | LEN_W | Number of words to program |
| base_addr | input | ADDR_W | Flash address of the first word |
| verify_en | input | 1 | Read back each word after programming |
| src_idx | output | LEN_W | Index of the current word in the source buffer |
| src_data | input | DATA_W | Source word at `src_idx` (combinational read) |
| fl_addr | output | ADDR_W | Flash bus address |
| fl_wdata | output | DATA_W | Flash bus write data |
| fl_we | output | 1 | Flash write strobe, one cycle per write |
| fl_re | output | 1 | Flash read strobe; data returns next cycle |
| fl_rdata | input | DATA_W | Flash read data, valid the cycle after `fl_re` |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| error | output | 1 | The last request failed |

## Verification
A bench-side flash model answers polls with the true word only after a chosen number of in-progress reads. Busy-poll counts of zero to six separate the single-read path from the repeated-poll path. A word whose fail bit comes up once and then clears, set against a word whose fail bit stays up, tells the successful re-read apart from the error stop. A stored word with bit 0 flipped passes polling and fails only the full-word compare, so that case isolates the verify path. The remaining patterns are:
- runs with verify off;
- a zero-length request;
- a stray start in the middle of a run.

Each is compared bus cycle by bus cycle against an expected event queue.

// File: rtl/flash_prog_pkg.sv
`timescale 1ns/1ps
package flash_prog_pkg;

    localparam int POLL_BIT = 7;
    localparam int FAIL_BIT = 5;

    localparam logic [11:0] UNLK_ADDR_A = 12'h555;
    localparam logic [11:0] UNLK_ADDR_B = 12'h2AA;
    localparam logic [7:0]  UNLK_DATA_A = 8'hAA;
    localparam logic [7:0]  UNLK_DATA_B = 8'h55;
    localparam logic [7:0]  PGM_SETUP   = 8'hA0;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UNLK1,
        ST_UNLK2,
        ST_SETUP,
        ST_WORD,
        ST_POLL_RD,
        ST_POLL_EV,
        ST_RECHK_RD,
        ST_RECHK_EV,
        ST_VER_RD,
        ST_VER_EV,
        ST_NEXT,
        ST_FAIL,
        ST_FIN
    } prog_state_e;

endpackage

// File: rtl/flash_prog_cursor.sv
`timescale 1ns/1ps
module flash_prog_cursor #(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              capture,
    input  logic              advance,
    input  logic [LEN_W-1:0]  len,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [DATA_W-1:0] src_data,
    output logic [LEN_W-1:0]  src_idx,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] word,
    output logic              is_last
);

    logic [LEN_W-1:0]  idx_q;
    logic [LEN_W-1:0]  len_q;
    logic [ADDR_W-1:0] base_q;
    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            len_q  <= '0;
            base_q <= '0;
        end else if (load) begin
            idx_q  <= '0;
            len_q  <= len;
            base_q <= base_addr;
        end else if (advance) begin
            idx_q  <= idx_q + LEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (capture) begin
            word_q <= src_data;
        end
    end

    assign src_idx  = idx_q;
    assign cur_addr = base_q + ADDR_W'(idx_q);
    assign word     = word_q;
    assign is_last  = (idx_q == len_q - LEN_W'(1));

endmodule

// File: rtl/flash_prog_status.sv
`timescale 1ns/1ps
module flash_prog_status
    import flash_prog_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] expect_word,
    output logic              poll_done,
    output logic              poll_fail,
    output logic              ver_ok
);

    always_comb begin
        poll_done = (rdata[POLL_BIT] == expect_word[POLL_BIT]);
        poll_fail = rdata[FAIL_BIT] && !poll_done;
        ver_ok    = (rdata == expect_word);
    end

endmodule

// File: rtl/flash_prog_fsm.sv
`timescale 1ns/1ps
module flash_prog_fsm
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              len_zero,
    input  logic              verify_en,
    input  logic              is_last,
    input  logic              poll_done,
    input  logic              poll_fail,
    input  logic              ver_ok,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [DATA_W-1:0] word,
    output logic              load,
    output logic              capture,
    output logic              advance,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    output logic              busy,
    output logic              done,
    output logic              error
);

    prog_state_e state_q, state_d;
    logic        ver_q;
    logic        err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ver_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                ver_q <= verify_en;
                err_q <= 1'b0;
            end else if (state_q == ST_FAIL) begin
                err_q <= 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = len_zero ? ST_FIN : ST_UNLK1;
                end
            end
            ST_UNLK1:    state_d = ST_UNLK2;
            ST_UNLK2:    state_d = ST_SETUP;
            ST_SETUP:    state_d = ST_WORD;
            ST_WORD:     state_d = ST_POLL_RD;
            ST_POLL_RD:  state_d = ST_POLL_EV;
            ST_POLL_EV: begin
                if (poll_done) begin
                    state_d = ver_q ? ST_VER_RD : ST_NEXT;
                end else if (poll_fail) begin
                    state_d = ST_RECHK_RD;
                end else begin
                    state_d = ST_POLL_RD;
                end
            end
            ST_RECHK_RD: state_d = ST_RECHK_EV;
            ST_RECHK_EV: begin
                if (poll_done) begin
                    state_d = ver_q ? ST_VER_RD : ST_NEXT;
                end else begin
                    state_d = ST_FAIL;
                end
            end
            ST_VER_RD:   state_d = ST_VER_EV;
            ST_VER_EV:   state_d = ver_ok ? ST_NEXT : ST_FAIL;
            ST_NEXT:     state_d = is_last ? ST_FIN : ST_UNLK1;
            ST_FAIL:     state_d = ST_FIN;
            ST_FIN:      state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load      = 1'b0;
        capture   = 1'b0;
        advance   = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        done      = 1'b0;
        busy      = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE: begin
                load = start && !len_zero;
            end
            ST_UNLK1: begin
                capture   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = ADDR_W'(UNLK_ADDR_A);
                bus_wdata = DATA_W'(UNLK_DATA_A);
            end
            ST_UNLK2: begin
                bus_we    = 1'b1;
                bus_addr  = ADDR_W'(UNLK_ADDR_B);
                bus_wdata = DATA_W'(UNLK_DATA_B);
            end
            ST_SETUP: begin
                bus_we    = 1'b1;
                bus_addr  = ADDR_W'(UNLK_ADDR_A);
                bus_wdata = DATA_W'(PGM_SETUP);
            end
            ST_WORD: begin
                bus_we    = 1'b1;
                bus_addr  = cur_addr;
                bus_wdata = word;
            end
            ST_POLL_RD, ST_RECHK_RD, ST_VER_RD: begin
                bus_re   = 1'b1;
                bus_addr = cur_addr;
            end
            ST_POLL_EV, ST_RECHK_EV, ST_VER_EV, ST_FAIL: begin
            end
            ST_NEXT: begin
                advance = !is_last;
            end
            ST_FIN: begin
                done = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign error = err_q;

endmodule

// File: rtl/flash_prog_ctrl.sv
`timescale 1ns/1ps
module flash_prog_ctrl #(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  len,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              verify_en,
    output logic [LEN_W-1:0]  src_idx,
    input  logic [DATA_W-1:0] src_data,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    output logic              fl_we,
    output logic              fl_re,
    input  logic [DATA_W-1:0] fl_rdata,
    output logic              busy,
    output logic              done,
    output logic              error
);

    logic              load, capture, advance;
    logic              is_last;
    logic              poll_done, poll_fail, ver_ok;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] word;
    logic              len_zero;

    assign len_zero = (len == '0);

    flash_prog_cursor #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .LEN_W (LEN_W)
    ) u_cursor (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .capture  (capture),
        .advance  (advance),
        .len      (len),
        .base_addr(base_addr),
        .src_data (src_data),
        .src_idx  (src_idx),
        .cur_addr (cur_addr),
        .word     (word),
        .is_last  (is_last)
    );

    flash_prog_status #(
        .DATA_W(DATA_W)
    ) u_status (
        .rdata      (fl_rdata),
        .expect_word(word),
        .poll_done  (poll_done),
        .poll_fail  (poll_fail),
        .ver_ok     (ver_ok)
    );

    flash_prog_fsm #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .len_zero (len_zero),
        .verify_en(verify_en),
        .is_last  (is_last),
        .poll_done(poll_done),
        .poll_fail(poll_fail),
        .ver_ok   (ver_ok),
        .cur_addr (cur_addr),
        .word     (word),
        .load     (load),
        .capture  (capture),
        .advance  (advance),
        .bus_addr (fl_addr),
        .bus_wdata(fl_wdata),
        .bus_we   (fl_we),
        .bus_re   (fl_re),
        .busy     (busy),
        .done     (done),
        .error    (error)
    );

endmodule

// File: rtl/flash_prog_ctrl_chk.sv
`timescale 1ns/1ps
module flash_prog_ctrl_chk #(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [LEN_W-1:0]  len,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [DATA_W-1:0] fl_wdata,
    input logic              fl_we,
    input logic              fl_re,
    input logic              busy,
    input logic              done,
    input logic              error
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fl_we && !fl_re && !done));

    p_first_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && len != '0) |=>
            (fl_we && fl_addr == ADDR_W'(12'h555) && fl_wdata == DATA_W'(8'hAA)));

    p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && len == '0) |=> (done && !fl_we && !fl_re));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_error_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(error));

    p_busy_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_re));

    p_read_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fl_re |=> !fl_re);

endmodule

bind flash_prog_ctrl flash_prog_ctrl_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LEN_W (LEN_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .len     (len),
    .fl_addr (fl_addr),
    .fl_wdata(fl_wdata),
    .fl_we   (fl_we),
    .fl_re   (fl_re),
    .busy    (busy),
    .done    (done),
    .error   (error)
);

// File: tb/flash_prog_ctrl_tb.sv
`timescale 1ns/1ps
module flash_prog_ctrl_tb;

    localparam int AW = 22;
    localparam int DW = 16;
    localparam int LW = 8;

    localparam int M_OK   = 0;
    localparam int M_FAIL = 1;
    localparam int M_REC  = 2;
    localparam int M_VBAD = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] len = '0;
    logic [AW-1:0] base_addr = '0;
    logic          verify_en = 1'b0;
    logic [LW-1:0] src_idx;
    logic [DW-1:0] src_data;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_wdata;
    logic          fl_we, fl_re;
    logic [DW-1:0] fl_rdata = '0;
    logic          busy, done, error;

    always #2.5 clk = ~clk;

    logic [DW-1:0] src_mem [0:255];
    logic [DW-1:0] fmem    [0:255];
    int            wmode   [0:255];
    int            wdelay  [0:255];
    int            pcnt    [0:255];
    logic [AW-1:0] base_tb = '0;
    int            wcnt = 0;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    int            q_kind [$];
    logic [AW-1:0] q_addr [$];
    logic [DW-1:0] q_data [$];
    string         q_req  [$];

    assign src_data = src_mem[src_idx];

    flash_prog_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .len(len),
        .base_addr(base_addr), .verify_en(verify_en),
        .src_idx(src_idx), .src_data(src_data),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
        .fl_rdata(fl_rdata), .busy(busy), .done(done), .error(error)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] respond(input int i);
        logic [DW-1:0] v;
        logic [DW-1:0] busy_v;
        busy_v    = fmem[i];
        busy_v[7] = ~src_mem[i][7];
        busy_v[5] = 1'b0;
        v = fmem[i];
        case (wmode[i])
            M_FAIL: begin
                busy_v[5] = 1'b1;
                v = busy_v;
            end
            M_REC: begin
                if (pcnt[i] == 0) begin
                    busy_v[5] = 1'b1;
                    v = busy_v;
                end
            end
            default: begin
                if (pcnt[i] < wdelay[i]) v = busy_v;
            end
        endcase
        return v;
    endfunction

    // flash device model
    always @(posedge clk) begin
        if (rst_n && fl_we) begin
            if (wcnt == 3) begin
                logic [AW-1:0] d;
                d = fl_addr - base_tb;
                fmem[d[7:0]] = (wmode[d[7:0]] == M_VBAD) ? (fl_wdata ^ 16'h0001) : fl_wdata;
                pcnt[d[7:0]] = 0;
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end
        if (rst_n && fl_re) begin
            logic [AW-1:0] d;
            d = fl_addr - base_tb;
            fl_rdata <= respond(int'(d[7:0]));
            pcnt[d[7:0]] = pcnt[d[7:0]] + 1;
        end
    end

    // per-cycle comparison of bus activity against the reference queue
    always @(negedge clk) begin
        if (rst_n && (fl_we || fl_re)) begin
            chk(!(fl_we && fl_re), "R11 strobes", {30'd0, fl_we, fl_re}, 32'd0);
            if (q_kind.size() == 0) begin
                chk(1'b0, "R7 unexpected bus cycle", 32'(fl_addr), 32'hFFFFFFFF);
            end else begin
                int            k;
                logic [AW-1:0] a;
                logic [DW-1:0] dd;
                string         r;
                k  = q_kind.pop_front();
                a  = q_addr.pop_front();
                dd = q_data.pop_front();
                r  = q_req.pop_front();
                chk(fl_we == (k == 0), r, {31'd0, fl_we}, {31'd0, (k == 0)});
                chk(fl_addr == a, r, 32'(fl_addr), 32'(a));
                if (k == 0) chk(fl_wdata == dd, r, 32'(fl_wdata), 32'(dd));
            end
        end
    end

    task automatic push(input int k, input logic [AW-1:0] a, input logic [DW-1:0] d, input string r);
        q_kind.push_back(k);
        q_addr.push_back(a);
        q_data.push_back(d);
        q_req.push_back(r);
    endtask

    task automatic set_all(input int m, input int dl);
        for (int i = 0; i < 256; i++) begin
            wmode[i]  = m;
            wdelay[i] = dl;
            fmem[i]   = '0;
            pcnt[i]   = 0;
            src_mem[i] = 16'(i * 16'h2B59 + 16'h80A5);
        end
    endtask

    task automatic run_op(input logic [AW-1:0] b, input int n, input bit ver,
                          input bit poke, input string req);
        bit stop;
        bit exp_err;
        int cyc;
        bit seen;
        stop = 0;
        exp_err = 0;
        q_kind.delete(); q_addr.delete(); q_data.delete(); q_req.delete();
        for (int i = 0; i < n && !stop; i++) begin
            logic [AW-1:0] ta;
            ta = b + AW'(i);
            push(0, 22'h555, 16'h00AA, "R2 unlock1");
            push(0, 22'h2AA, 16'h0055, "R2 unlock2");
            push(0, 22'h555, 16'h00A0, "R2 setup");
            push(0, ta, src_mem[i], "R7 data write");
            case (wmode[i])
                M_FAIL: begin
                    push(1, ta, '0, "R4 poll");
                    push(1, ta, '0, "R4 reread");
                    stop = 1; exp_err = 1;
                end
                M_REC: begin
                    push(1, ta, '0, "R4 poll");
                    push(1, ta, '0, "R4 reread");
                    if (ver) push(1, ta, '0, "R5 verify");
                end
                default: begin
                    for (int k = 0; k <= wdelay[i]; k++) push(1, ta, '0, "R3 poll");
                    if (ver) push(1, ta, '0, "R5 verify");
                    if (wmode[i] == M_VBAD && ver) begin
                        stop = 1; exp_err = 1;
                    end
                end
            endcase
        end
        base_tb = b;
        @(negedge clk);
        start = 1'b1; base_addr = b; len = LW'(n); verify_en = ver;
        @(negedge clk);
        start = 1'b0;
        seen = 0;
        cyc = 1;
        if (done) seen = 1;
        if (poke && !seen) begin
            repeat (6) @(negedge clk);
            start = 1'b1; base_addr = 22'h3F0000; len = 8'd5; verify_en = 1'b0;
            @(negedge clk);
            start = 1'b0;
        end
        while (!seen && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (done) seen = 1;
        end
        chk(seen, {req, " R9 done seen"}, {31'd0, seen}, 32'd1);
        if (n == 0) chk(cyc <= 3, "R8 zero-length latency", 32'(cyc), 32'd3);
        chk(error == exp_err, {req, " error flag"}, {31'd0, error}, {31'd0, exp_err});
        chk(q_kind.size() == 0, {req, " R7 all bus cycles issued"}, 32'(q_kind.size()), 32'd0);
        if (!exp_err) begin
            for (int i = 0; i < n; i++)
                chk(fmem[i] == src_mem[i], "R7 flash content", 32'(fmem[i]), 32'(src_mem[i]));
        end
        @(negedge clk);
        chk(!done, "R9 done single cycle", {31'd0, done}, 32'd0);
        chk(!busy, "R1 idle after request", {31'd0, busy}, 32'd0);
        repeat (2) @(negedge clk);
        chk(error == exp_err, "R9 error held while idle", {31'd0, error}, {31'd0, exp_err});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        set_all(M_OK, 0);
        repeat (3) @(negedge clk);
        chk(!fl_we && !fl_re && !done && !busy, "R1 reset quiet",
            {28'd0, fl_we, fl_re, done, busy}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!error && !busy && !done, "R1 after reset", {29'd0, error, busy, done}, 32'd0);

        // R3 R7: polling with several busy lengths, verify on
        set_all(M_OK, 0);
        wdelay[1] = 1; wdelay[2] = 3; wdelay[3] = 6;
        run_op(22'h001000, 4, 1'b1, 1'b0, "R3");

        // R6: verify off
        set_all(M_OK, 2);
        run_op(22'h002000, 3, 1'b0, 1'b0, "R6");

        // R8: zero length
        set_all(M_OK, 0);
        run_op(22'h002800, 0, 1'b1, 1'b0, "R8");

        // R4: fail bit persists on word 1
        set_all(M_OK, 1);
        wmode[1] = M_FAIL;
        run_op(22'h003000, 3, 1'b1, 1'b0, "R4 stuck");

        // R4: fail bit seen once, then completion
        set_all(M_OK, 0);
        wmode[0] = M_REC;
        run_op(22'h004000, 2, 1'b1, 1'b0, "R4 recover");

        // R5: read-back mismatch on word 1
        set_all(M_OK, 1);
        wmode[1] = M_VBAD;
        run_op(22'h005000, 3, 1'b1, 1'b0, "R5 mismatch");

        // R10: stray start mid-run; also R9 error cleared by new request
        set_all(M_OK, 2);
        run_op(22'h006000, 2, 1'b1, 1'b1, "R10");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule